// File: doc/BRIEF.md
# SD Command Line Engine

This block owns the CMD wire of an SD card interface. On a start request it builds a 48-bit command frame from a 6-bit command index and a 32-bit argument, appends a CRC7, and shifts the frame out most significant bit first. Each bit is paced by a card-clock enable strobe that comes from an external divider.

After the frame has gone out, the engine does one of two things, depending on the response type latched at start. It may finish at once. Otherwise it releases the line and listens for a 48-bit or a 136-bit reply from the card. A received reply is unpacked into a response index and up to four 32-bit response words. Short replies can have their CRC7 verified.

The outcome is reported through sticky flags, which the host clears by writing ones. An active signal spans the whole transaction.

Top module: `sd_cmd_engine`

## Requirements
- R1: On each of the first 48 card-clock strobes after an accepted start, `cmd_out` presents the next bit of the frame. The frame is start 0, direction 1, index[5:0], argument[31:0], CRC7[6:0], end 1, sent MSB first. `cmd_oe` is high for those 48 bit times. The 49th strobe drops `cmd_oe` and returns `cmd_out` to 1.
- R2: CRC7 uses the polynomial x^7+x^3+1 with a zero initial value, computed over the first 40 frame bits. Index 0 with argument 0 gives the frame 0x400000000095. Index 8 with argument 0x1AA gives 0x48000001AA87.
- R3: With no response selected, the 49th strobe sets the sent flag (`flags[3]`) and ends the transaction. The line stays released whenever the engine is inactive.
- R4: A short reply starts with a 0 on `cmd_in` and is 48 bits long. Reply bits [45:40] go to `resp_index`, and bits [39:8] go to `resp_w1`. Words 2 to 4 are left unchanged. A good reply sets the response flag (`flags[0]`).
- R5: A long reply is 136 bits. Its reserved bits [133:128] go to `resp_index`. Bits [127:0] go to `resp_w1`..`resp_w4`, most significant word in `resp_w1`. No CRC is checked, and `flags[0]` is set.
- R6: A short reply with CRC checking enabled whose bits [7:1] differ from the CRC7 of bits [47:8] sets the CRC-failure flag (`flags[1]`) and not `flags[0]`. The response registers are still loaded.
- R7: With `crc_check_en` low at start, a short reply with a wrong CRC field sets `flags[0]` and never `flags[1]`.
- R8: After the line is released, the engine samples `cmd_in` on each strobe. If it sees 64 consecutive high samples (`TIMEOUT_CYCLES`), it sets only the timeout flag (`flags[2]`) and goes idle. A start bit on the 64th sample is still accepted.
- R9: Flags are sticky. A 1 in `flag_clr[k]` clears `flags[k]` only, and the other flags are kept.
- R10: `active` rises the cycle after an accepted start and falls in the cycle a flag is set. A start while active is ignored, and the frame in flight is unchanged.
- R11: The response type encoding is 2'b00 none, 2'b01 short, 2'b10 long, 2'b11 none.
- R12: `cmd_out` and `cmd_oe` change only on cycles where `clk_en` is high.
- R13: After reset, `flags` is 0, `active` is 0, `cmd_oe` is 0 and `cmd_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Card-clock strobe pacing CMD bits |
| cmd_arg | input | 32 | Command argument |
| cmd_index | input | 6 | Command index |
| resp_type | input | 2 | Response type: 00 none, 01 short, 10 long, 11 none |
| crc_check_en | input | 1 | Enable CRC7 check on a short reply |
| cmd_start | input | 1 | Start request, taken when idle |
| flag_clr | input | 4 | Write-1-to-clear for `flags` |
| cmd_in | input | 1 | CMD line as seen from the card |
| cmd_out | output | 1 | CMD value driven to the card |
| cmd_oe | output | 1 | CMD drive enable |
| active | output | 1 | Transaction in progress |
| flags | output | 4 | Sticky flags: [0] reply ok, [1] CRC fail, [2] timeout, [3] sent |
| resp_index | output | 6 | Index field of the last reply |
| resp_w1 | output | 32 | Response word 1 (most significant) |
| resp_w2 | output | 32 | Response word 2 |
| resp_w3 | output | 32 | Response word 3 |
| resp_w4 | output | 32 | Response word 4 (least significant) |

## Verification
The command table drives every response type, including the alias encoding. It pairs good and corrupted CRC fields with the check turned on and off, so a CRC failure is told apart from a CRC that was skipped. The start bit arrives after delays of 0 to 63 strobes. Those runs separate the last accepted wait from a timeout, which a separate run with 64 idle samples triggers. Two known frames pin the CRC polynomial and seed. Directed runs inject a second start mid-frame, and clear one flag while another is held, which distinguishes per-bit clearing from a global reset of the flags.

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine #(
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clk_en,
  input  logic [31:0] cmd_arg,
  input  logic [5:0]  cmd_index,
  input  logic [1:0]  resp_type,
  input  logic        crc_check_en,
  input  logic        cmd_start,
  input  logic [3:0]  flag_clr,
  input  logic        cmd_in,
  output logic        cmd_out,
  output logic        cmd_oe,
  output logic        active,
  output logic [3:0]  flags,
  output logic [5:0]  resp_index,
  output logic [31:0] resp_w1,
  output logic [31:0] resp_w2,
  output logic [31:0] resp_w3,
  output logic [31:0] resp_w4
);
  localparam int FRAME_BITS = 48;
  localparam int LONG_BITS  = 136;
  localparam int KEEP_BITS  = LONG_BITS - 2;
  localparam int TCW = $clog2(FRAME_BITS + 1);
  localparam int RCW = $clog2(LONG_BITS + 1);
  localparam int WCW = $clog2(TIMEOUT_CYCLES + 1);
  localparam int F_OK = 0, F_CRC = 1, F_TO = 2, F_SENT = 3;

  typedef enum logic [2:0] {S_IDLE, S_TX, S_WAIT, S_RX, S_CHECK} st_t;

  function automatic logic [6:0] crc7_of(input logic [39:0] d);
    logic [6:0] c;
    logic fb;
    c = 7'd0;
    for (int i = 39; i >= 0; i--) begin
      fb = d[i] ^ c[6];
      c  = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    return c;
  endfunction

  st_t                  state;
  logic [FRAME_BITS-2:0] tx_sr;
  logic [TCW-1:0]       tx_cnt;
  logic [WCW-1:0]       wait_cnt;
  logic [RCW-1:0]       rx_cnt;
  logic [KEEP_BITS-1:0] rx_sr;
  logic [1:0]           typ_q;
  logic                 crc_en_q;
  logic [3:0]           set_vec;

  wire want_short = (typ_q == 2'b01);
  wire want_long  = (typ_q == 2'b10);
  wire want_resp  = want_short | want_long;

  wire [39:0] tx_head = {2'b01, cmd_index, cmd_arg};
  wire [FRAME_BITS-1:0] tx_frame = {tx_head, crc7_of(tx_head), 1'b1};

  wire tx_last   = (tx_cnt == TCW'(FRAME_BITS));
  wire wait_last = (wait_cnt == WCW'(TIMEOUT_CYCLES - 1));
  wire [RCW-1:0] rx_last = want_long ? RCW'(LONG_BITS - 1) : RCW'(FRAME_BITS - 1);
  wire crc_bad = (crc7_of(rx_sr[47:8]) != rx_sr[7:1]);

  assign active = (state != S_IDLE);

  assign set_vec[F_SENT] = (state == S_TX) && clk_en && tx_last && !want_resp;
  assign set_vec[F_TO]   = (state == S_WAIT) && clk_en && cmd_in && wait_last;
  assign set_vec[F_CRC]  = (state == S_CHECK) && want_short && crc_en_q && crc_bad;
  assign set_vec[F_OK]   = (state == S_CHECK) && !set_vec[F_CRC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= 4'b0;
    else        flags <= (flags & ~flag_clr) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      tx_sr      <= '0;
      tx_cnt     <= '0;
      wait_cnt   <= '0;
      rx_cnt     <= '0;
      rx_sr      <= '0;
      typ_q      <= 2'b00;
      crc_en_q   <= 1'b0;
      cmd_out    <= 1'b1;
      cmd_oe     <= 1'b0;
      resp_index <= '0;
      resp_w1    <= '0;
      resp_w2    <= '0;
      resp_w3    <= '0;
      resp_w4    <= '0;
    end else begin
      case (state)
        S_IDLE: if (cmd_start) begin
          tx_sr    <= tx_frame[FRAME_BITS-2:0];
          cmd_out  <= 1'b1;
          typ_q    <= resp_type;
          crc_en_q <= crc_check_en;
          tx_cnt   <= '0;
          state    <= S_TX;
        end
        S_TX: if (clk_en) begin
          if (tx_last) begin
            cmd_oe   <= 1'b0;
            cmd_out  <= 1'b1;
            wait_cnt <= '0;
            state    <= want_resp ? S_WAIT : S_IDLE;
          end else begin
            cmd_oe  <= 1'b1;
            cmd_out <= (tx_cnt == '0) ? 1'b0 : tx_sr[FRAME_BITS-2];
            if (tx_cnt != '0) tx_sr <= {tx_sr[FRAME_BITS-3:0], 1'b0};
            tx_cnt  <= tx_cnt + 1'b1;
          end
        end
        S_WAIT: if (clk_en) begin
          if (!cmd_in) begin
            rx_sr  <= {rx_sr[KEEP_BITS-2:0], cmd_in};
            rx_cnt <= RCW'(1);
            state  <= S_RX;
          end else if (wait_last) begin
            state <= S_IDLE;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        S_RX: if (clk_en) begin
          rx_sr  <= {rx_sr[KEEP_BITS-2:0], cmd_in};
          rx_cnt <= rx_cnt + 1'b1;
          if (rx_cnt == rx_last) state <= S_CHECK;
        end
        S_CHECK: begin
          if (want_long) begin
            resp_index <= rx_sr[133:128];
            resp_w1    <= rx_sr[127:96];
            resp_w2    <= rx_sr[95:64];
            resp_w3    <= rx_sr[63:32];
            resp_w4    <= rx_sr[31:0];
          end else begin
            resp_index <= rx_sr[45:40];
            resp_w1    <= rx_sr[39:8];
          end
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module sd_cmd_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clk_en,
  input logic       cmd_start,
  input logic [3:0] flag_clr,
  input logic       active,
  input logic [3:0] flags,
  input logic       cmd_out,
  input logic       cmd_oe
);
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flags & ~$past(flags))); // R6
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((~flags & $past(flags) & ~$past(flag_clr)) == 4'b0)); // R9
  AST_FLAG_ENDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags & ~$past(flags))) |-> !active); // R10
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && !active) |=> active); // R10
  AST_LINE_PACED: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(cmd_out) && $stable(cmd_oe))); // R12
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !cmd_oe); // R3
endmodule

bind sd_cmd_engine sd_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cmd_start(cmd_start),
  .flag_clr(flag_clr), .active(active), .flags(flags),
  .cmd_out(cmd_out), .cmd_oe(cmd_oe)
);

// File: tb/sd_cmd_engine_bench.sv
module sd_cmd_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 64;
  localparam int NV = 7;

  logic clk = 1'b0, rst_n = 1'b0, clk_en = 1'b0;
  logic [31:0] cmd_arg = '0;
  logic [5:0] cmd_index = '0;
  logic [1:0] resp_type = '0;
  logic crc_check_en = 1'b0, cmd_start = 1'b0, cmd_in = 1'b1;
  logic [3:0] flag_clr = '0;
  logic cmd_out, cmd_oe, active;
  logic [3:0] flags;
  logic [5:0] resp_index;
  logic [31:0] resp_w1, resp_w2, resp_w3, resp_w4;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_cmd_engine #(.TIMEOUT_CYCLES(TMO)) u_sd_cmd_engine (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cmd_arg(cmd_arg),
    .cmd_index(cmd_index), .resp_type(resp_type), .crc_check_en(crc_check_en),
    .cmd_start(cmd_start), .flag_clr(flag_clr), .cmd_in(cmd_in),
    .cmd_out(cmd_out), .cmd_oe(cmd_oe), .active(active), .flags(flags),
    .resp_index(resp_index), .resp_w1(resp_w1), .resp_w2(resp_w2),
    .resp_w3(resp_w3), .resp_w4(resp_w4));

  localparam logic [5:0]   V_IDX  [NV] = '{6'd17, 6'd0, 6'd2, 6'd41, 6'd13, 6'd55, 6'd8};
  localparam logic [31:0]  V_ARG  [NV] = '{32'h0000_1000, 32'h0, 32'h0, 32'h40FF_8000,
                                          32'h1234_0000, 32'hAAAA_5555, 32'h0000_01AA};
  localparam logic [1:0]   V_TYP  [NV] = '{2'b01, 2'b00, 2'b10, 2'b01, 2'b01, 2'b11, 2'b01};
  localparam bit           V_CE   [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam bit           V_BAD  [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
  localparam int           V_DLY  [NV] = '{2, 0, 5, 1, 0, 0, 63};
  localparam logic [5:0]   V_RIDX [NV] = '{6'd17, 6'd0, 6'h3F, 6'h3F, 6'd13, 6'd0, 6'd8};
  localparam logic [127:0] V_PAY  [NV] = '{
    {32'h0000_0900, 96'h0}, 128'h0,
    128'h1D41_4453_4D53_4420_1000_0012_3400_8A5B,
    {32'hC0FF_8000, 96'h0}, {32'h0000_0B00, 96'h0}, 128'h0,
    {32'h0000_01AA, 96'h0}};
  localparam logic [3:0]   V_FLG  [NV] = '{4'b0001, 4'b1000, 4'b0001, 4'b0001, 4'b0010, 4'b1000, 4'b0001};
  localparam string        V_REQ  [NV] = '{"R4", "R3", "R5", "R7", "R6", "R11", "R8"};

  function automatic logic [6:0] calc_crc7(input logic [39:0] d);
    logic [6:0] r = 7'd0;
    for (int i = 39; i >= 0; i--) begin
      logic top = r[6] ^ d[i];
      r = {r[5:0], 1'b0};
      if (top) r = r ^ 7'b000_1001;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [135:0] act, input logic [135:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk) clk_en = 1'b1;
    @(negedge clk) clk_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] typ,
                         input bit ce, input bit corrupt, input int delay,
                         input logic [5:0] ridx, input logic [127:0] pay,
                         input int poke_at, output logic [47:0] txcap);
    logic [135:0] rsp;
    int len;
    bit oe_ok = 1'b1;
    @(negedge clk);
    cmd_index = idx; cmd_arg = arg; resp_type = typ; crc_check_en = ce; cmd_start = 1'b1;
    @(negedge clk) cmd_start = 1'b0;
    repeat (4) @(negedge clk);
    chk(active && !cmd_oe, "R12", "no drive before first strobe", {cmd_oe, active}, 2'b01);
    txcap = '0;
    for (int k = 0; k < 48; k++) begin
      if (k == poke_at) begin
        cmd_index = ~idx; cmd_arg = ~arg; cmd_start = 1'b1;
        @(negedge clk) cmd_start = 1'b0;
      end
      strobe();
      txcap = {txcap[46:0], cmd_out};
      if (!cmd_oe) oe_ok = 1'b0;
    end
    chk(oe_ok, "R1", "cmd_oe during frame", oe_ok, 1'b1);
    strobe();
    chk(!cmd_oe && cmd_out, "R1", "line released after frame", {cmd_oe, cmd_out}, 2'b01);
    if (typ == 2'b01 || typ == 2'b10) begin
      if (typ == 2'b01) begin
        len = 48;
        rsp = '0;
        rsp[47:8] = {2'b00, ridx, pay[127:96]};
        rsp[7:1] = calc_crc7(rsp[47:8]) ^ (corrupt ? 7'h55 : 7'h00);
        rsp[0] = 1'b1;
      end else begin
        len = 136;
        rsp = {2'b00, ridx, pay};
      end
      for (int d = 0; d < delay; d++) strobe();
      if (delay < TMO) begin
        for (int b = len - 1; b >= 0; b--) begin
          cmd_in = rsp[b];
          strobe();
        end
      end
      cmd_in = 1'b1;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_flags(input logic [3:0] m);
    @(negedge clk) flag_clr = m;
    @(negedge clk) flag_clr = 4'b0;
  endtask

  initial begin
    logic [47:0] cap, expf;
    logic [39:0] head;
    repeat (3) @(negedge clk);
    chk(flags == 4'b0 && !active && !cmd_oe && cmd_out, "R13", "reset state",
        {flags, active, cmd_oe, cmd_out}, 7'b0000_001);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      run_cmd(V_IDX[v], V_ARG[v], V_TYP[v], V_CE[v], V_BAD[v], V_DLY[v],
              V_RIDX[v], V_PAY[v], -1, cap);
      head = {2'b01, V_IDX[v], V_ARG[v]};
      expf = {head, calc_crc7(head), 1'b1};
      chk(cap == expf, "R1", "transmitted frame", cap, expf);
      chk(flags == V_FLG[v], V_REQ[v], "outcome flags", flags, V_FLG[v]);
      chk(!active, "R10", "inactive after outcome", active, 1'b0);
      if (V_TYP[v] == 2'b01) begin
        chk(resp_w1 == V_PAY[v][127:96], "R4", "short payload", resp_w1, V_PAY[v][127:96]);
        chk(resp_index == V_RIDX[v], "R4", "short index", resp_index, V_RIDX[v]);
      end
      if (V_TYP[v] == 2'b10) begin
        chk({resp_w1, resp_w2, resp_w3, resp_w4} == V_PAY[v], "R5", "long words",
            {resp_w1, resp_w2, resp_w3, resp_w4}, V_PAY[v]);
        chk(resp_index == V_RIDX[v], "R5", "long reserved index", resp_index, V_RIDX[v]);
      end
      clear_flags(4'hF);
      chk(flags == 4'b0, "R9", "clear all", flags, 4'b0);
    end

    run_cmd(6'd0, 32'h0, 2'b00, 1'b0, 1'b0, 0, 6'd0, 128'h0, -1, cap);
    chk(cap == 48'h4000_0000_0095, "R2", "CRC of index 0", cap, 48'h4000_0000_0095);
    clear_flags(4'hF);
    run_cmd(6'd8, 32'h1AA, 2'b00, 1'b0, 1'b0, 0, 6'd0, 128'h0, -1, cap);
    chk(cap == 48'h4800_0001_AA87, "R2", "CRC of index 8", cap, 48'h4800_0001_AA87);

    run_cmd(6'd9, 32'h0001_0000, 2'b01, 1'b1, 1'b0, TMO, 6'd9, 128'h0, -1, cap);
    chk(flags == 4'b1100, "R8", "timeout only, sent kept", flags, 4'b1100);
    chk(!active, "R8", "idle after timeout", active, 1'b0);
    chk(resp_w1 == 32'h0000_01AA, "R8", "response words untouched", resp_w1, 32'h0000_01AA);

    clear_flags(4'b0100);
    chk(flags == 4'b1000, "R9", "clear timeout keeps sent", flags, 4'b1000);
    repeat (20) @(negedge clk);
    chk(flags == 4'b1000, "R9", "sent flag sticky", flags, 4'b1000);
    clear_flags(4'hF);

    run_cmd(6'd24, 32'hDEAD_BEEF, 2'b00, 1'b0, 1'b0, 0, 6'd0, 128'h0, 10, cap);
    head = {2'b01, 6'd24, 32'hDEAD_BEEF};
    expf = {head, calc_crc7(head), 1'b1};
    chk(cap == expf, "R10", "start ignored while active", cap, expf);
    repeat (10) @(negedge clk);
    chk(!active && flags == 4'b1000, "R10", "no second transaction", {active, flags}, 5'b01000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule